// File: doc/BRIEF.md
# Control Endpoint Status Register

This block is the 32-bit control and status word for the control endpoint of a USB device. The processor reads and writes it over a plain bus with an address, a write enable, write data and combinational read data. Endpoint logic reports events on single-cycle set inputs, and those events latch sticky status bits. Two level inputs are shown live in the word. Software turns on actions by writing ones, and each bit has its own rule for what a one does.

There are four access types in the low byte. Write-one-to-clear bits hold hardware events until software acknowledges them. Command bits turn a written one into a single-cycle pulse toward the endpoint logic and always read back as zero. One write-one-to-set bit holds a stall request, and hardware clears it when the stall handshake has gone out. The remaining bits are read-only mirrors. Writing a zero never changes anything. The upper 24 bits are reserved.

Top module: `ep_ctl_csr`

## Requirements
- R1: While rst_ni is low, the stored status bits are 0, force_stall_o is 0 and both pulse outputs are 0.
- R2: rdata_o shows the status word when addr_i equals CSR_ADDR (default 0x10) and is 0 at any other address. Bits 31:8 of rdata_o are always 0.
- R3: Bit 0 (OUT data ready), bit 4 (stall handshake sent) and bit 7 (setup in progress) are sticky. out_pkt_set_i, stall_sent_set_i and setup_set_i each set their own bit at a clock edge. Once set, a bit stays at 1 until a write to CSR_ADDR with a 1 in that bit position clears it.
- R4: If a hardware set input and a write-one-to-clear reach the same sticky bit at the same edge, the bit ends up at 1.
- R5: A write of 0 to any bit leaves that bit unchanged. A write to any address other than CSR_ADDR changes no state and produces no pulse.
- R6: A write to CSR_ADDR with bit 1 set drives in_pkt_rdy_pulse_o high for exactly the one cycle after that write edge. Bit 1 always reads as 0.
- R7: A write to CSR_ADDR with bit 2 set drives tx_flush_pulse_o high for exactly the one cycle after that write edge. Bit 2 always reads as 0.
- R8: A write of 1 to bit 5 sets the force-stall state. That state reads back in bit 5 and drives force_stall_o. Writing 0 to bit 5 does not clear it.
- R9: stall_sent_set_i clears the force-stall state at the same edge at which it sets bit 4. If a software write sets bit 5 at that same edge, the software set wins.
- R10: Bit 3 always equals remote_wake_en_i and bit 6 always equals rx_not_empty_i. Writes to bits 3 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |
| out_pkt_set_i | input | 1 | Event: an OUT packet has arrived |
| stall_sent_set_i | input | 1 | Event: a stall handshake was sent |
| setup_set_i | input | 1 | Event: a setup transaction has started |
| remote_wake_en_i | input | 1 | Level: remote wakeup is enabled |
| rx_not_empty_i | input | 1 | Level: the receive FIFO holds data |
| in_pkt_rdy_pulse_o | output | 1 | One-cycle pulse: the IN packet is loaded |
| tx_flush_pulse_o | output | 1 | One-cycle pulse: flush the transmit FIFO |
| force_stall_o | output | 1 | Force-stall state |

## Verification
Directed sequences cover the cases that random traffic seldom lines up:
- a set event and a clear at the same edge, which separates set priority from clear priority;
- writes of all zeros and writes to a foreign address, which show that no state leaks;
- back-to-back command writes, which show that pulses do not stretch;
- a stall event together with a software force-stall write.

Random traffic then mixes writes, events and level changes across both matching and foreign addresses. A bench model predicts every field of the word and every output each cycle, so a wrong priority, a lost event or a misplaced bit shows up as a mismatch in a named field.

// File: rtl/ep_csr_pkg.sv
package ep_csr_pkg;
  localparam int unsigned USED_W = 8;

  // bit positions decoded by firmware
  localparam int unsigned POS_OUT_RDY   = 0;
  localparam int unsigned POS_IN_RDY    = 1;
  localparam int unsigned POS_TX_FLUSH  = 2;
  localparam int unsigned POS_WAKE_EN   = 3;
  localparam int unsigned POS_STL_SENT  = 4;
  localparam int unsigned POS_FRC_STALL = 5;
  localparam int unsigned POS_RX_NE     = 6;
  localparam int unsigned POS_SETUP     = 7;

  localparam int unsigned NUM_STICKY = 3;
  localparam int unsigned NUM_CMD    = 2;

  typedef struct packed {
    logic setup;
    logic stall_sent;
    logic out_rdy;
  } sticky_t;

  function automatic logic [USED_W-1:0] pack_status(
    input sticky_t s, input logic force_stall, input logic wake_en, input logic rx_ne);
    logic [USED_W-1:0] w;
    w                = '0;
    w[POS_OUT_RDY]   = s.out_rdy;
    w[POS_WAKE_EN]   = wake_en;
    w[POS_STL_SENT]  = s.stall_sent;
    w[POS_FRC_STALL] = force_stall;
    w[POS_RX_NE]     = rx_ne;
    w[POS_SETUP]     = s.setup;
    return w;
  endfunction
endpackage

// File: rtl/ep_csr_decode.sv
module ep_csr_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned USED_W   = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rd_hit_o,
  output logic [USED_W-1:0] wr_one_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:USED_W];
  assign rd_hit_o  = (addr_i == CSR_ADDR);
  assign wr_one_o  = (we_i && rd_hit_o) ? wdata_i[USED_W-1:0] : '0;
endmodule

// File: rtl/ep_csr_sticky.sv
// hardware set beats software clear
module ep_csr_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ep_csr_pulse.sv
module ep_csr_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= fire_i;
  end
endmodule

// File: rtl/ep_csr_force.sv
// software set beats hardware clear
module ep_csr_force (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_set_i,
  input  logic hw_clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (sw_set_i) q_o <= 1'b1;
    else if (hw_clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ep_ctl_csr.sv
module ep_ctl_csr
  import ep_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              out_pkt_set_i,
  input  logic              stall_sent_set_i,
  input  logic              setup_set_i,
  input  logic              remote_wake_en_i,
  input  logic              rx_not_empty_i,
  output logic              in_pkt_rdy_pulse_o,
  output logic              tx_flush_pulse_o,
  output logic              force_stall_o
);
  localparam int unsigned STICKY_POS [NUM_STICKY] = '{POS_OUT_RDY, POS_STL_SENT, POS_SETUP};
  localparam int unsigned CMD_POS    [NUM_CMD]    = '{POS_IN_RDY, POS_TX_FLUSH};

  logic              rd_hit;
  logic [USED_W-1:0] wr_one;
  logic [NUM_STICKY-1:0] hw_set;
  logic [NUM_STICKY-1:0] sticky_q;
  logic [NUM_CMD-1:0]    cmd_pulse;
  sticky_t           sticky_s;
  logic [USED_W-1:0] status_w;

  ep_csr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USED_W(USED_W), .CSR_ADDR(CSR_ADDR)
  ) i_decode (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .rd_hit_o (rd_hit),
    .wr_one_o (wr_one)
  );

  assign hw_set = {setup_set_i, stall_sent_set_i, out_pkt_set_i};

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    ep_csr_sticky i_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (hw_set[g]),
      .clr_i  (wr_one[STICKY_POS[g]]),
      .q_o    (sticky_q[g])
    );
  end

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    ep_csr_pulse i_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (wr_one[CMD_POS[g]]),
      .pulse_o (cmd_pulse[g])
    );
  end

  ep_csr_force i_force (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_set_i (wr_one[POS_FRC_STALL]),
    .hw_clr_i (stall_sent_set_i),
    .q_o      (force_stall_o)
  );

  assign in_pkt_rdy_pulse_o = cmd_pulse[0];
  assign tx_flush_pulse_o   = cmd_pulse[1];
  assign sticky_s = '{setup: sticky_q[2], stall_sent: sticky_q[1], out_rdy: sticky_q[0]};
  assign status_w = pack_status(sticky_s, force_stall_o, remote_wake_en_i, rx_not_empty_i);

  always_comb begin
    rdata_o = '0;
    if (rd_hit) rdata_o[USED_W-1:0] = status_w;
  end
endmodule

// File: rtl/ep_ctl_csr_chk.sv
module ep_ctl_csr_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              out_pkt_set_i,
  input logic              stall_sent_set_i,
  input logic              setup_set_i,
  input logic              remote_wake_en_i,
  input logic              rx_not_empty_i,
  input logic              in_pkt_rdy_pulse_o,
  input logic              tx_flush_pulse_o,
  input logic              force_stall_o,
  input logic [2:0]        sticky_q
);
  logic wr_hit;
  assign wr_hit = we_i && (addr_i == CSR_ADDR);

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_R1: assert (sticky_q == '0 && !force_stall_o &&
                                          !in_pkt_rdy_pulse_o && !tx_flush_pulse_o);

  assert_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:8] == '0 && rdata_o[2:1] == 2'b00);
  assert_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i != CSR_ADDR |-> rdata_o == '0);
  assert_out_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_pkt_set_i |=> sticky_q[0]);
  assert_stall_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit && wdata_i[4] && !stall_sent_set_i |=> !sticky_q[1]);
  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit && wdata_i[7] && setup_set_i |=> sticky_q[2]);
  assert_in_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt_rdy_pulse_o |-> $past(wr_hit && wdata_i[1]));
  assert_flush_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_pulse_o |-> $past(wr_hit && wdata_i[2]));
  assert_force_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit && wdata_i[5] |=> force_stall_o);
  assert_force_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_sent_set_i && !(wr_hit && wdata_i[5]) |=> !force_stall_o);
  assert_mirror_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == CSR_ADDR |-> rdata_o[3] == remote_wake_en_i && rdata_o[6] == rx_not_empty_i);
endmodule

bind ep_ctl_csr ep_ctl_csr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_ADDR(CSR_ADDR)
) i_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .addr_i             (addr_i),
  .we_i               (we_i),
  .wdata_i            (wdata_i),
  .rdata_o            (rdata_o),
  .out_pkt_set_i      (out_pkt_set_i),
  .stall_sent_set_i   (stall_sent_set_i),
  .setup_set_i        (setup_set_i),
  .remote_wake_en_i   (remote_wake_en_i),
  .rx_not_empty_i     (rx_not_empty_i),
  .in_pkt_rdy_pulse_o (in_pkt_rdy_pulse_o),
  .tx_flush_pulse_o   (tx_flush_pulse_o),
  .force_stall_o      (force_stall_o),
  .sticky_q           (sticky_q)
);

// File: tb/test_ep_ctl_csr.sv
`timescale 1ns/1ps
module test_ep_ctl_csr;
  localparam logic [7:0] A = 8'h10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic out_pkt_set_i = 0, stall_sent_set_i = 0, setup_set_i = 0;
  logic remote_wake_en_i = 0, rx_not_empty_i = 0;
  logic in_pkt_rdy_pulse_o, tx_flush_pulse_o, force_stall_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_opr = 0, m_sst = 0, m_sa = 0, m_fst = 0, m_inp = 0, m_flp = 0;

  always #10 clk_i = ~clk_i;

  ep_ctl_csr i_ep_ctl_csr (.*);

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] exp_word();
    return {24'h0, m_sa, rx_not_empty_i, m_fst, m_sst, remote_wake_en_i, 2'b00, m_opr};
  endfunction

  task automatic check_read();
    logic [31:0] e;
    #1;
    e = exp_word();
    if (addr_i != A) chk(rdata_o === 32'h0, "R2", rdata_o, 32'h0);
    else begin
      chk(rdata_o[31:8] === 24'h0, "R2", rdata_o, e);
      chk(rdata_o[0] === e[0] && rdata_o[4] === e[4] && rdata_o[7] === e[7], "R3", rdata_o, e);
      chk(rdata_o[1] === 1'b0, "R6", rdata_o, e);
      chk(rdata_o[2] === 1'b0, "R7", rdata_o, e);
      chk(rdata_o[5] === e[5], "R8", rdata_o, e);
      chk(rdata_o[3] === e[3] && rdata_o[6] === e[6], "R10", rdata_o, e);
    end
  endtask

  task automatic tick();
    bit hit;
    @(posedge clk_i);
    hit   = we_i && addr_i == A;
    m_opr = out_pkt_set_i | (m_opr & !(hit & wdata_i[0]));
    m_sst = stall_sent_set_i | (m_sst & !(hit & wdata_i[4]));
    m_sa  = setup_set_i | (m_sa & !(hit & wdata_i[7]));
    m_fst = (hit & wdata_i[5]) | (m_fst & !stall_sent_set_i);
    m_inp = hit & wdata_i[1];
    m_flp = hit & wdata_i[2];
    @(negedge clk_i);
    chk(in_pkt_rdy_pulse_o === m_inp, "R6", {31'h0, in_pkt_rdy_pulse_o}, {31'h0, m_inp});
    chk(tx_flush_pulse_o === m_flp, "R7", {31'h0, tx_flush_pulse_o}, {31'h0, m_flp});
    chk(force_stall_o === m_fst, "R8", {31'h0, force_stall_o}, {31'h0, m_fst});
  endtask

  task automatic step(input logic [7:0] a, input bit w, input logic [31:0] d,
                      input bit o, input bit s, input bit u, input bit wk, input bit rx);
    addr_i = a; we_i = w; wdata_i = d;
    out_pkt_set_i = o; stall_sent_set_i = s; setup_set_i = u;
    remote_wake_en_i = wk; rx_not_empty_i = rx;
    check_read();
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    addr_i = A;
    repeat (3) @(negedge clk_i);
    #1;
    chk(rdata_o === 32'h0, "R1", rdata_o, 32'h0);
    chk(!force_stall_o && !in_pkt_rdy_pulse_o && !tx_flush_pulse_o, "R1",
        {29'h0, force_stall_o, in_pkt_rdy_pulse_o, tx_flush_pulse_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 set then clear
    step(A, 0, 0, 1, 1, 1, 0, 0);
    step(A, 1, 32'h11, 0, 0, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0, 0);
    chk(rdata_o[7] === 1'b1 && rdata_o[0] === 1'b0, "R3", rdata_o, 32'h80);
    // R4 set beats clear at the same edge
    step(A, 1, 32'h81, 1, 0, 1, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0, 0);
    chk(rdata_o[0] === 1'b1 && rdata_o[7] === 1'b1, "R4", rdata_o, 32'h81);
    // R5 zero writes and foreign address
    step(A, 0, 0, 0, 1, 0, 0, 0);
    step(A, 1, 32'h0, 0, 0, 0, 0, 0);
    step(8'h14, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0, 0);
    chk(rdata_o === 32'h91 && !in_pkt_rdy_pulse_o && !tx_flush_pulse_o, "R5", rdata_o, 32'h91);
    // R6 R7 back-to-back commands
    step(A, 1, 32'h06, 0, 0, 0, 0, 0);
    step(A, 1, 32'h02, 0, 0, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0, 0);
    // R8 set, zero write keeps it
    step(A, 1, 32'h20, 0, 0, 0, 0, 0);
    step(A, 1, 32'h00, 0, 0, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0, 0);
    // R9 hardware clear, then simultaneous software set
    step(A, 0, 0, 0, 1, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0, 0);
    chk(rdata_o[5] === 1'b0 && rdata_o[4] === 1'b1, "R9", rdata_o, 32'h91);
    step(A, 1, 32'h20, 0, 1, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0, 0);
    chk(force_stall_o === 1'b1, "R9", {31'h0, force_stall_o}, 32'h1);
    // R10 mirrors, writes ignored
    step(A, 1, 32'h48, 0, 0, 0, 1, 0);
    step(A, 1, 32'h48, 0, 0, 0, 0, 1);
    step(A, 0, 0, 0, 0, 0, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : A;
      step(a, ($urandom % 2) == 1, $urandom,
           ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 4) == 0,
           ($urandom % 2) == 1, ($urandom % 2) == 1);
    end
    finish_run();
  end
endmodule